// File: doc/BRIEF.md
# Port-Write Unlock Sequence Detector

This block watches byte writes on a CPU I/O bus. It counts only writes whose upper address byte selects the display controller's register-select port. It looks for a keyed run of sixteen bytes on that port. The run is a synchronisation pair (any nonzero byte followed by 0x00), then thirteen fixed key bytes, then a state byte. The state byte decides the outcome. The unlock code 0xCD sets the unlocked flag. Any other value clears it. A byte written after the state byte has no effect on the flag.

The flag gates the write enable of an extra gate-array configuration register. The decode of that register sits outside this block. Its write request arrives at this block, and the block passes it on only while the flag is set. Each lock or unlock decision also produces a one-cycle pulse. A separate output carries each kind of pulse.

The matcher tolerates noise. A wrong byte sends it back to hunting. A wrong nonzero byte counts as a fresh first byte. A wrong 0x00 that follows a nonzero byte counts as a fresh synchronisation pair. Writes to other ports leave the progress untouched.

Top module: `seq_unlock_detect`

## Requirements
- R1: After reset, unlocked_o is 0, both pulse outputs are 0 and the matcher is hunting.
- R2: Only writes with wr_i=1 and addr_i[15:8]=0xBC are observed. Writes with any other upper address byte, and cycles with wr_i=0, change neither the flag nor the matcher's progress.
- R3: A run starts with a nonzero byte followed by 0x00.
- R4: After the 0x00, the next thirteen port bytes must be, in order: 0xFF, 0x77, 0xB3, 0x51, 0xA8, 0xD4, 0x62, 0x39, 0x9C, 0x46, 0x2B, 0x15, 0x8A.
- R5: A state byte of 0xCD following 0x8A sets unlocked_o in the cycle after that write.
- R6: Any state byte other than 0xCD following 0x8A clears unlocked_o in the cycle after that write.
- R7: Each decision raises exactly one of unlock_pulse_o (code 0xCD) or lock_pulse_o (other code) for exactly one cycle, in the cycle after the state-byte write.
- R8: A byte that does not match the expected step causes a restart. A nonzero mismatch acts as a new first byte. A 0x00 mismatch after a nonzero byte acts as a new synchronisation pair. A 0x00 mismatch after 0x00 returns the matcher to hunting.
- R9: Outside a decision, the flag holds its value. This includes the byte written right after the state byte.
- R10: ext_wr_en_o equals ext_wr_i while unlocked_o is 1, and is 0 while unlocked_o is 0, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | I/O write strobe, one write per cycle |
| addr_i | input | 16 | I/O port address |
| wdata_i | input | 8 | I/O write data |
| ext_wr_i | input | 1 | Decoded write request for the extra configuration register |
| unlocked_o | output | 1 | Unlocked status flag |
| unlock_pulse_o | output | 1 | One-cycle pulse on an unlock decision |
| lock_pulse_o | output | 1 | One-cycle pulse on a lock decision |
| ext_wr_en_o | output | 1 | Write request for the extra register, gated by the flag |

## Verification
The flag and both pulses are registered. They change at the rising edge that captures the state-byte write. The bench samples them at the next falling edge and expects the pulse to be gone one falling edge later. The gated enable is combinational, so it is compared at the same falling edge as the request that drives it. The reference model takes each port write at the rising edge and runs its comparison at every falling edge. Directed checks after each sequence use that same falling-edge sample point, so no expected value is read half a cycle early.

// File: rtl/seq_unlock_pkg.sv
package seq_unlock_pkg;
  localparam int KEY_LEN = 13;

  function automatic logic [7:0] key_byte(input logic [3:0] idx);
    logic [7:0] k;
    case (idx)
      4'd0:  k = 8'hFF;
      4'd1:  k = 8'h77;
      4'd2:  k = 8'hB3;
      4'd3:  k = 8'h51;
      4'd4:  k = 8'hA8;
      4'd5:  k = 8'hD4;
      4'd6:  k = 8'h62;
      4'd7:  k = 8'h39;
      4'd8:  k = 8'h9C;
      4'd9:  k = 8'h46;
      4'd10: k = 8'h2B;
      4'd11: k = 8'h15;
      4'd12: k = 8'h8A;
      default: k = 8'h00;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/seq_port_filter.sv
module seq_port_filter #(
  parameter int          ADDR_W   = 16,
  parameter int          SEL_W    = 8,
  parameter logic [SEL_W-1:0] PORT_SEL = 8'hBC
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  assign hit_o = wr_i && (addr_i[ADDR_W-1 -: SEL_W] == PORT_SEL);
endmodule

// File: rtl/seq_step_tracker.sv
module seq_step_tracker
  import seq_unlock_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] UNLOCK_CODE = 8'hCD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              decide_o,
  output logic              code_ok_o
);
  localparam int STEPS = KEY_LEN + 3;          // pair + key + state byte
  localparam int SW    = $clog2(STEPS);
  localparam logic [SW-1:0] S_HUNT = '0;
  localparam logic [SW-1:0] S_ONE  = SW'(1);
  localparam logic [SW-1:0] S_TWO  = SW'(2);
  localparam logic [SW-1:0] S_LAST = SW'(STEPS - 1);

  logic [SW-1:0] step_q, step_d;
  logic          nz;
  logic [3:0]    kidx;

  assign nz   = |data_i;
  assign kidx = 4'(step_q - S_TWO);

  always_comb begin
    step_d = step_q;
    if (hit_i) begin
      if (step_q == S_LAST)                  step_d = S_HUNT;
      else if (step_q == S_HUNT)             step_d = nz ? S_ONE : S_HUNT;
      else if (step_q == S_ONE)              step_d = nz ? S_ONE : S_TWO;
      else if (data_i == key_byte(kidx))     step_d = step_q + S_ONE;
      else if (nz)                           step_d = S_ONE;   // fresh first byte
      else if (step_q == S_TWO)              step_d = S_HUNT;  // zero after zero
      else                                   step_d = S_TWO;   // fresh sync pair
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= S_HUNT;
    else         step_q <= step_d;
  end

  assign decide_o  = hit_i && (step_q == S_LAST);
  assign code_ok_o = (data_i == UNLOCK_CODE);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(step_q));
  assert_zero_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !nz) |=> (step_q <= S_TWO));
  assert_nz_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && nz && step_q != S_LAST) |=> (step_q != S_HUNT));
endmodule

// File: rtl/seq_unlock_flag.sv
module seq_unlock_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic decide_i,
  input  logic code_ok_i,
  output logic unlocked_o,
  output logic unlock_pulse_o,
  output logic lock_pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_o     <= 1'b0;
      unlock_pulse_o <= 1'b0;
      lock_pulse_o   <= 1'b0;
    end else begin
      if (decide_i) unlocked_o <= code_ok_i;
      unlock_pulse_o <= decide_i && code_ok_i;
      lock_pulse_o   <= decide_i && !code_ok_i;
    end
  end

  assert_flag_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decide_i |=> $stable(unlocked_o));
  assert_pulse_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({unlock_pulse_o, lock_pulse_o}));
  assert_pulse_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_pulse_o || lock_pulse_o) |=> !(unlock_pulse_o || lock_pulse_o));
  assert_unlock_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_pulse_o |-> unlocked_o);
  assert_lock_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_pulse_o |-> !unlocked_o);
endmodule

// File: rtl/seq_unlock_detect.sv
module seq_unlock_detect #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 8,
  parameter logic [SEL_W-1:0]  PORT_SEL    = 8'hBC,
  parameter logic [DATA_W-1:0] UNLOCK_CODE = 8'hCD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ext_wr_i,
  output logic              unlocked_o,
  output logic              unlock_pulse_o,
  output logic              lock_pulse_o,
  output logic              ext_wr_en_o
);
  logic hit, decide, code_ok;

  seq_port_filter #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .PORT_SEL(PORT_SEL)) u_filter (
    .wr_i(wr_i), .addr_i(addr_i), .hit_o(hit)
  );

  seq_step_tracker #(.DATA_W(DATA_W), .UNLOCK_CODE(UNLOCK_CODE)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .data_i(wdata_i),
    .decide_o(decide), .code_ok_o(code_ok)
  );

  seq_unlock_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .decide_i(decide), .code_ok_i(code_ok),
    .unlocked_o(unlocked_o), .unlock_pulse_o(unlock_pulse_o), .lock_pulse_o(lock_pulse_o)
  );

  assign ext_wr_en_o = ext_wr_i && unlocked_o;

  assert_ext_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_pulse_o && ext_wr_i) |-> !ext_wr_en_o);
endmodule

// File: tb/seq_unlock_detect_test.sv
module seq_unlock_detect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [7:0]  wdata = 8'h0;
  logic        ext_wr = 1'b0;
  logic        unlocked, upulse, lpulse, ext_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seq_unlock_detect uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .ext_wr_i(ext_wr), .unlocked_o(unlocked), .unlock_pulse_o(upulse),
    .lock_pulse_o(lpulse), .ext_wr_en_o(ext_en)
  );

  logic [7:0] key [13] = '{8'hFF, 8'h77, 8'hB3, 8'h51, 8'hA8, 8'hD4, 8'h62,
                           8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A};

  // Reference model: history of port bytes since the last decision.
  logic [7:0] hist [$];
  bit m_flag = 0, m_up = 0, m_lp = 0;

  function automatic bit tail_matches();
    int n = hist.size();
    if (n < 16) return 0;
    if (hist[n-16] == 8'h00) return 0;
    if (hist[n-15] != 8'h00) return 0;
    for (int i = 0; i < 13; i++)
      if (hist[n-14+i] != key[i]) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete(); m_flag <= 0; m_up <= 0; m_lp <= 0;
    end else begin
      m_up <= 0; m_lp <= 0;
      if (wr && addr[15:8] == 8'hBC) begin
        hist.push_back(wdata);
        if (tail_matches()) begin
          m_flag <= (wdata == 8'hCD);
          m_up   <= (wdata == 8'hCD);
          m_lp   <= (wdata != 8'hCD);
          hist.delete();
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(unlocked == m_flag, "R5 R6 R9 flag", unlocked, m_flag);
    check(upulse == m_up, "R7 unlock pulse", upulse, m_up);
    check(lpulse == m_lp, "R7 lock pulse", lpulse, m_lp);
    check(ext_en == (ext_wr & m_flag), "R10 ext enable", ext_en, ext_wr & m_flag);
  end

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 0;
  endtask

  task automatic put_key();
    for (int i = 0; i < 13; i++) put(16'hBC00, key[i]);
  endtask

  task automatic full_seq(input logic [7:0] first, input logic [7:0] st);
    put(16'hBC00, first); put(16'hBC00, 8'h00); put_key(); put(16'hBC00, st);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(unlocked == 0 && upulse == 0 && lpulse == 0, "R1 reset state",
          {unlocked, upulse, lpulse}, 0);
    #1 rst_n = 1;
    repeat (2) @(negedge clk);
    check(unlocked == 0, "R1 locked after reset", unlocked, 0);

    // R10 locked: request blocked
    #1 ext_wr = 1;
    @(negedge clk);
    check(ext_en == 0, "R10 blocked while locked", ext_en, 0);
    #1 ext_wr = 0;

    // R3 R4 R5 full unlock
    full_seq(8'hFF, 8'hCD);
    @(negedge clk);
    check(unlocked == 1, "R5 unlock", unlocked, 1);
    check(upulse == 1, "R7 unlock pulse", upulse, 1);
    @(negedge clk);
    check(upulse == 0, "R7 pulse one cycle", upulse, 0);
    #1 ext_wr = 1;
    @(negedge clk);
    check(ext_en == 1, "R10 passed while unlocked", ext_en, 1);
    #1 ext_wr = 0;

    // R9 trailing byte ignored
    put(16'hBC00, 8'h00);
    @(negedge clk);
    check(unlocked == 1, "R9 trailing byte", unlocked, 1);

    // R6 lock with other code, other-port writes mixed in (R2)
    put(16'hBC00, 8'h42); put(16'hBC00, 8'h00);
    for (int i = 0; i < 13; i++) begin
      put(16'hBC00, key[i]);
      if (i == 5) begin
        put(16'hBD00, 8'h11); put(16'h7F00, 8'h00); put(16'h00BC, 8'hAA);
      end
    end
    put(16'hBC00, 8'h12);
    @(negedge clk);
    check(unlocked == 0, "R6 lock", unlocked, 0);
    check(lpulse == 1, "R7 lock pulse", lpulse, 1);
    check(upulse == 0, "R7 no unlock pulse", upulse, 0);

    // R8 broken sequence: no decision
    put(16'hBC00, 8'h01); put(16'hBC00, 8'h00);
    for (int i = 0; i < 6; i++) put(16'hBC00, key[i]);
    put(16'hBC00, 8'h33);
    for (int i = 6; i < 13; i++) put(16'hBC00, key[i]);
    put(16'hBC00, 8'hCD);
    @(negedge clk);
    check(unlocked == 0 && upulse == 0, "R8 broken sequence", unlocked, 0);

    // R8 restart in middle with nonzero then zero
    put(16'hBC00, 8'h80); put(16'hBC00, 8'h00);
    for (int i = 0; i < 4; i++) put(16'hBC00, key[i]);
    full_seq(8'h05, 8'hCD);
    @(negedge clk);
    check(unlocked == 1, "R8 restart resync", unlocked, 1);

    // R8 zero mismatch after key byte acts as new sync pair; lock code 0x00
    put(16'hBC00, 8'h09); put(16'hBC00, 8'h00);
    put(16'hBC00, key[0]); put(16'hBC00, key[1]);
    put(16'hBC00, 8'h00); put_key(); put(16'hBC00, 8'h00);
    @(negedge clk);
    check(unlocked == 0 && lpulse == 1, "R8 zero resync lock", unlocked, 0);

    // R2 writes with wr low do not count
    put(16'hBC00, 8'hFF); put(16'hBC00, 8'h00);
    @(negedge clk); #1 addr = 16'hBC00; wdata = 8'h55;
    repeat (3) @(negedge clk);
    put_key(); put(16'hBC00, 8'hCD);
    @(negedge clk);
    check(unlocked == 1, "R2 idle bus ignored", unlocked, 1);

    // R1 reset mid-unlocked
    #1 rst_n = 0;
    @(negedge clk);
    check(unlocked == 0, "R1 reset clears", unlocked, 0);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule